// File: doc/BRIEF.md
# Masked Multi-Channel Register Select

This block sits on a byte-wide processor bus and claims a 64-byte window at 0xE000–0xE03F. The lower 32 bytes of the window belong to up to eight identical channel devices that all decode the same register offsets. An 8-bit enable mask, one bit per channel, decides which devices take part in an access. A write in the channel range goes to every enabled channel at once, so one bus cycle can program several channels with the same value.

Reads cannot be broadcast. Several devices driving the shared return bus at the same time would cause contention, so the block counts the set mask bits before it forwards a read. A read is passed through only when exactly one bit is set. With several bits set, the read is blocked: no channel is selected, the bus sees 0xFF, and a sticky error flag records the event. With no bits set, no channel is selected and the bus sees 0xFF, but the error flag does not change. The upper half of the window holds the mask register and the error status.

Every access is latched on the clock edge where the strobe is sampled. It is then carried out by a small state machine in the following cycle. The states are IDLE, CH_WR (channel broadcast write), CH_RD (channel read, forwarded or blocked), REG_WR (control write) and REG_RD (control read). From any state, a strobe inside the window moves the machine to the state given by the address half and the direction. A cycle with no strobe inside the window moves it to IDLE.

Top module: `mcs_chan_select`

## Requirements
- R1: A strobe whose address lies outside 0xE000–0xE03F gives no acknowledge and no channel select, and it changes neither the mask nor the error flag.
- R2: An access sampled at one rising edge is acknowledged (`bus_ack` = 1) for exactly the following clock cycle. The acknowledge is never asserted without a strobe at the previous edge.
- R3: A write to 0xE000–0xE01F drives `ch_sel` equal to the mask for one cycle, with `ch_we` = 1, `ch_addr` = address bits [4:0] and `ch_wdata` = the written byte. Outside this state, `ch_we` = 0 and `ch_wdata` = 0x00.
- R4: A read from 0xE000–0xE01F with exactly one mask bit set selects only that channel, with `ch_we` = 0 and `ch_addr` = address bits [4:0]. `bus_rdata` then returns `ch_rdata`.
- R5: A channel-range read with two or more mask bits set drives `ch_sel` = 0 and `bus_rdata` = 0xFF, and it sets the error flag from the next cycle onward.
- R6: A channel-range read with the mask at 0x00 drives `ch_sel` = 0 and `bus_rdata` = 0xFF, and it leaves the error flag unchanged.
- R7: The mask register sits at 0xE020. It can be written and read back, and it resets to 0x00.
- R8: The status register sits at 0xE021. Bit 0 is the sticky error flag and the other bits read 0. A write with bit 0 = 1 clears the flag, and a write with bit 0 = 0 leaves it set. `err_flag` always shows the flag.
- R9: Offsets 0xE022–0xE03F are acknowledged and read 0x00. Writes to them change nothing.
- R10: After reset, `bus_ack`, `ch_sel`, `ch_we`, `err_flag` and `bus_rdata` are all 0. `bus_rdata` stays 0x00 in every cycle that is not a read acknowledge.
- R11: A mask write affects the very next access, even when that access is issued on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 8 | Processor write data |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_strobe | input | 1 | Access request, sampled each rising edge |
| bus_rdata | output | 8 | Read data returned in the acknowledge cycle |
| bus_ack | output | 1 | Access completes this cycle |
| ch_sel | output | 8 | Per-channel select, bit i for channel i |
| ch_we | output | 1 | Channel write enable |
| ch_addr | output | 5 | Register offset within the channel range |
| ch_wdata | output | 8 | Data broadcast to the selected channels |
| ch_rdata | input | 8 | Shared return data from the channels |
| err_flag | output | 1 | Sticky blocked-read error flag |

## Verification
A wrong latched state would show up at the ports in the cycle right after the strobe edge. A select would appear on a write when it should be on a read, or the acknowledge would come without any select, or it would fall in the wrong cycle. The bench compares every cycle, including idle ones, so a misplaced or stretched acknowledge is caught on the edge where it occurs. A bad mask or a bad popcount class shows up either as a wrong `ch_sel` pattern or as a blocked read that returns channel data. A wrong error flag state can be read one cycle later through the status register and also on `err_flag`.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CH_WR,
        ST_CH_RD,
        ST_REG_WR,
        ST_REG_RD
    } acc_state_e;

    localparam int CTRL_MASK_OFS = 32;
    localparam int CTRL_STAT_OFS = 33;

endpackage

// File: rtl/mcs_window_decode.sv
module mcs_window_decode #(
    parameter int          AW       = 16,
    parameter int          WIN_BITS = 6,
    parameter int          CH_BITS  = 5,
    parameter logic [15:0] BASE     = 16'hE000
) (
    input  logic [AW-1:0]       addr,
    output logic                in_window,
    output logic                is_chan,
    output logic [WIN_BITS-1:0] offset
);
    localparam int TAG_W = AW - WIN_BITS;
    localparam logic [TAG_W-1:0] BASE_TAG = BASE[AW-1:WIN_BITS];

    always_comb begin
        in_window = (addr[AW-1:WIN_BITS] == BASE_TAG);
        offset    = addr[WIN_BITS-1:0];
        is_chan   = (addr[WIN_BITS-1:CH_BITS] == '0);
    end
endmodule

// File: rtl/mcs_mask_class.sv
module mcs_mask_class #(
    parameter int N_CH = 8
) (
    input  logic [N_CH-1:0] mask,
    output logic            single,
    output logic            multi
);
    localparam int CW = $clog2(N_CH + 1);

    logic [CW-1:0] partial [N_CH+1];

    assign partial[0] = '0;

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_pop
            assign partial[g+1] = partial[g] + {{(CW-1){1'b0}}, mask[g]};
        end
    endgenerate

    always_comb begin
        single = (partial[N_CH] == CW'(1));
        multi  = (partial[N_CH] > CW'(1));
    end
endmodule

// File: rtl/mcs_ctrl_regs.sv
module mcs_ctrl_regs #(
    parameter int N_CH = 8,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mask_we,
    input  logic [DW-1:0]   mask_wdata,
    input  logic            err_set,
    input  logic            err_clr,
    output logic [N_CH-1:0] mask_q,
    output logic            err_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= mask_wdata[N_CH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (err_set) begin
            err_q <= 1'b1;
        end else if (err_clr) begin
            err_q <= 1'b0;
        end
    end
endmodule

// File: rtl/mcs_access_fsm.sv
module mcs_access_fsm
    import mcs_pkg::*;
#(
    parameter int N_CH     = 8,
    parameter int DW       = 8,
    parameter int WIN_BITS = 6,
    parameter int CH_BITS  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe,
    input  logic                rnw,
    input  logic                in_window,
    input  logic                is_chan,
    input  logic [WIN_BITS-1:0] offset,
    input  logic [DW-1:0]       wdata,
    input  logic [N_CH-1:0]     mask_q,
    input  logic                mask_single,
    input  logic                mask_multi,
    input  logic                err_q,
    input  logic [DW-1:0]       ch_rdata,
    output logic                ack,
    output logic [DW-1:0]       rdata,
    output logic [N_CH-1:0]     ch_sel,
    output logic                ch_we,
    output logic [CH_BITS-1:0]  ch_addr,
    output logic [DW-1:0]       ch_wdata,
    output logic                mask_we,
    output logic [DW-1:0]       mask_wdata,
    output logic                err_set,
    output logic                err_clr
);
    localparam logic [WIN_BITS-1:0] OFS_MASK = WIN_BITS'(CTRL_MASK_OFS);
    localparam logic [WIN_BITS-1:0] OFS_STAT = WIN_BITS'(CTRL_STAT_OFS);
    localparam logic [DW-1:0]       IDLE_BUS = '1;

    acc_state_e          state_q, state_d;
    logic [WIN_BITS-1:0] off_q;
    logic [DW-1:0]       wdata_q;
    logic                take;

    assign take = strobe && in_window;

    // next-state selection
    always_comb begin
        state_d = ST_IDLE;
        if (take) begin
            if (is_chan) begin
                state_d = rnw ? ST_CH_RD : ST_CH_WR;
            end else begin
                state_d = rnw ? ST_REG_RD : ST_REG_WR;
            end
        end
    end

    // state register plus latched decode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            off_q   <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                off_q   <= offset;
                wdata_q <= wdata;
            end
        end
    end

    // outputs per state
    always_comb begin
        ack        = 1'b0;
        rdata      = '0;
        ch_sel     = '0;
        ch_we      = 1'b0;
        ch_addr    = '0;
        ch_wdata   = '0;
        mask_we    = 1'b0;
        mask_wdata = wdata_q;
        err_set    = 1'b0;
        err_clr    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_CH_WR: begin
                ack      = 1'b1;
                ch_sel   = mask_q;
                ch_we    = 1'b1;
                ch_addr  = off_q[CH_BITS-1:0];
                ch_wdata = wdata_q;
            end
            ST_CH_RD: begin
                ack     = 1'b1;
                ch_addr = off_q[CH_BITS-1:0];
                if (mask_single) begin
                    ch_sel = mask_q;
                    rdata  = ch_rdata;
                end else begin
                    rdata   = IDLE_BUS;
                    err_set = mask_multi;
                end
            end
            ST_REG_WR: begin
                ack     = 1'b1;
                mask_we = (off_q == OFS_MASK);
                err_clr = (off_q == OFS_STAT) && wdata_q[0];
            end
            ST_REG_RD: begin
                ack = 1'b1;
                if (off_q == OFS_MASK) begin
                    rdata = DW'(mask_q);
                end else if (off_q == OFS_STAT) begin
                    rdata = DW'(err_q);
                end
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/mcs_chan_select.sv
module mcs_chan_select #(
    parameter int          N_CH     = 8,
    parameter int          DW       = 8,
    parameter int          AW       = 16,
    parameter int          WIN_BITS = 6,
    parameter int          CH_BITS  = 5,
    parameter logic [15:0] BASE     = 16'hE000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    input  logic               bus_rnw,
    input  logic               bus_strobe,
    output logic [DW-1:0]      bus_rdata,
    output logic               bus_ack,
    output logic [N_CH-1:0]    ch_sel,
    output logic               ch_we,
    output logic [CH_BITS-1:0] ch_addr,
    output logic [DW-1:0]      ch_wdata,
    input  logic [DW-1:0]      ch_rdata,
    output logic               err_flag
);
    logic                in_window;
    logic                is_chan;
    logic [WIN_BITS-1:0] offset;
    logic [N_CH-1:0]     mask_q;
    logic                mask_single;
    logic                mask_multi;
    logic                err_q;
    logic                mask_we;
    logic [DW-1:0]       mask_wdata;
    logic                err_set;
    logic                err_clr;

    mcs_window_decode #(
        .AW(AW), .WIN_BITS(WIN_BITS), .CH_BITS(CH_BITS), .BASE(BASE)
    ) u_dec (
        .addr(bus_addr), .in_window(in_window), .is_chan(is_chan), .offset(offset)
    );

    mcs_mask_class #(.N_CH(N_CH)) u_cls (
        .mask(mask_q), .single(mask_single), .multi(mask_multi)
    );

    mcs_ctrl_regs #(.N_CH(N_CH), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .err_set(err_set), .err_clr(err_clr),
        .mask_q(mask_q), .err_q(err_q)
    );

    mcs_access_fsm #(
        .N_CH(N_CH), .DW(DW), .WIN_BITS(WIN_BITS), .CH_BITS(CH_BITS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .strobe(bus_strobe), .rnw(bus_rnw),
        .in_window(in_window), .is_chan(is_chan), .offset(offset),
        .wdata(bus_wdata),
        .mask_q(mask_q), .mask_single(mask_single), .mask_multi(mask_multi),
        .err_q(err_q), .ch_rdata(ch_rdata),
        .ack(bus_ack), .rdata(bus_rdata),
        .ch_sel(ch_sel), .ch_we(ch_we), .ch_addr(ch_addr), .ch_wdata(ch_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .err_set(err_set), .err_clr(err_clr)
    );

    assign err_flag = err_q;
endmodule

// File: rtl/mcs_chan_select_chk.sv
module mcs_chan_select_chk #(
    parameter int N_CH = 8,
    parameter int DW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_strobe,
    input logic            bus_ack,
    input logic [DW-1:0]   bus_rdata,
    input logic [N_CH-1:0] ch_sel,
    input logic            ch_we,
    input logic [N_CH-1:0] mask_q,
    input logic            err_flag
);
    a_r2_ack_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_strobe));

    a_r3_write_follows_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ch_we |-> (bus_ack && ch_sel == mask_q));

    a_r4_read_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !ch_we && ch_sel != '0) |-> ($onehot(ch_sel) && ch_sel == mask_q));

    a_r5_multi_read_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !ch_we && $countones(mask_q) > 1) |-> (ch_sel == '0));

    a_r5_err_from_blocked_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(bus_ack && !ch_we && ch_sel == '0 && bus_rdata == '1));

    a_r1_select_only_when_acked: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_sel != '0) |-> bus_ack);
endmodule

bind mcs_chan_select mcs_chan_select_chk #(.N_CH(N_CH), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .ch_sel(ch_sel), .ch_we(ch_we),
    .mask_q(mask_q), .err_flag(err_flag)
);

// File: tb/sim_mcs_chan_select.sv
module sim_mcs_chan_select;

    typedef struct packed {
        logic       ack;
        logic [7:0] sel;
        logic       we;
        logic [4:0] caddr;
        logic [7:0] cwdata;
        logic [7:0] rdata;
        logic       err;
        logic [7:0] req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rnw = 1'b0;
    logic        bus_strobe = 1'b0;
    logic [7:0]  bus_rdata;
    logic        bus_ack;
    logic [7:0]  ch_sel;
    logic        ch_we;
    logic [4:0]  ch_addr;
    logic [7:0]  ch_wdata;
    logic [7:0]  ch_rdata;
    logic        err_flag;

    int   n_vec = 0;
    int   n_bad = 0;
    exp_t q[$];
    logic [7:0] mask_m = 8'h00;
    logic       err_m  = 1'b0;
    logic       done   = 1'b0;

    always #10 clk = ~clk;

    mcs_chan_select u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rnw(bus_rnw), .bus_strobe(bus_strobe), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .ch_sel(ch_sel), .ch_we(ch_we), .ch_addr(ch_addr),
        .ch_wdata(ch_wdata), .ch_rdata(ch_rdata), .err_flag(err_flag)
    );

    // channel model: each device returns 0xA0 plus its index
    always_comb begin
        ch_rdata = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (ch_sel[i]) ch_rdata = 8'hA0 + 8'(i);
        end
    end

    // driver: one bus cycle, expected response pushed for the next cycle
    task automatic cyc(input logic stb, input logic [15:0] a, input logic rnw,
                       input logic [7:0] d, input logic [7:0] req);
        exp_t e;
        logic [5:0] off;
        logic       inwin;
        int         cnt;
        @(negedge clk);
        bus_strobe = stb;
        bus_addr   = a;
        bus_rnw    = rnw;
        bus_wdata  = d;
        off   = a[5:0];
        inwin = (a[15:6] == 10'h380);
        e = '0;
        e.err = err_m;
        e.req = req;
        if (stb && inwin) begin
            e.ack = 1'b1;
            if (off < 6'd32) begin
                e.caddr = off[4:0];
                if (!rnw) begin
                    e.sel = mask_m; e.we = 1'b1; e.cwdata = d;
                end else begin
                    cnt = $countones(mask_m);
                    if (cnt == 1) begin
                        e.sel = mask_m;
                        for (int i = 0; i < 8; i++) if (mask_m[i]) e.rdata = 8'hA0 + 8'(i);
                    end else begin
                        e.rdata = 8'hFF;
                        if (cnt > 1) err_m = 1'b1;
                    end
                end
            end else if (!rnw) begin
                if (off == 6'h20) mask_m = d;
                if (off == 6'h21 && d[0]) err_m = 1'b0;
            end else begin
                if (off == 6'h20) e.rdata = mask_m;
                else if (off == 6'h21) e.rdata = {7'b0, err_m};
            end
        end
        q.push_back(e);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [7:0] req);
        cyc(1'b1, a, 1'b0, d, req);
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] req);
        cyc(1'b1, a, 1'b1, 8'h00, req);
    endtask

    task automatic idle(input logic [7:0] req);
        cyc(1'b0, 16'hE000, 1'b1, 8'h00, req);
    endtask

    // monitor: compares outputs a quarter period after each rising edge
    always @(posedge clk) begin
        #5;
        if (rst_n && q.size() > 0) begin
            exp_t e;
            exp_t a;
            e = q.pop_front();
            a = '{ack: bus_ack, sel: ch_sel, we: ch_we, caddr: ch_addr,
                  cwdata: ch_wdata, rdata: bus_rdata, err: err_flag, req: e.req};
            n_vec++;
            if (a != e) begin
                n_bad++;
                $display("FAIL R%0d: ack=%b sel=%h we=%b addr=%h wd=%h rd=%h err=%b, expected ack=%b sel=%h we=%b addr=%h wd=%h rd=%h err=%b",
                         e.req, a.ack, a.sel, a.we, a.caddr, a.cwdata, a.rdata, a.err,
                         e.ack, e.sel, e.we, e.caddr, e.cwdata, e.rdata, e.err);
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL R2: watchdog expired, actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        n_vec++;
        if (bus_ack !== 1'b0 || ch_sel !== 8'h00 || ch_we !== 1'b0 ||
            err_flag !== 1'b0 || bus_rdata !== 8'h00) begin
            n_bad++;
            $display("FAIL R10: ack=%b sel=%h we=%b err=%b rd=%h expected all zero",
                     bus_ack, ch_sel, ch_we, err_flag, bus_rdata);
        end
        rst_n = 1'b1;
        idle(10);
        rd(16'hE020, 7);                 // R7 reset mask 0x00
        rd(16'hE004, 6);                 // R6 empty mask read
        rd(16'hE021, 6);                 // R6 error untouched
        wr(16'hE020, 8'h04, 11);         // R11 mask then immediate write
        wr(16'hE005, 8'h5A, 3);          // R3 single channel write
        rd(16'hE003, 4);                 // R4 forwarded read
        idle(2);                         // R2 one-cycle acknowledge
        wr(16'hE020, 8'hA5, 7);
        rd(16'hE020, 7);                 // R7 readback
        wr(16'hE01F, 8'h33, 3);          // R3 broadcast
        rd(16'hE010, 5);                 // R5 blocked read
        rd(16'hE021, 5);                 // R5 error now set
        rd(16'hE000, 5);
        wr(16'hE021, 8'hFE, 8);          // R8 bit0=0 keeps flag
        rd(16'hE021, 8);
        wr(16'hE021, 8'h01, 8);          // R8 clear
        rd(16'hE021, 8);
        wr(16'hE060, 8'h11, 1);          // R1 aliases mask offset outside window
        wr(16'hDFE0, 8'h11, 1);
        rd(16'hE040, 1);
        wr(16'hF021, 8'h01, 1);
        rd(16'hE020, 1);                 // R1 mask unchanged
        wr(16'hE025, 8'hFF, 9);          // R9 unmapped offset
        wr(16'hE03F, 8'h00, 9);
        rd(16'hE025, 9);
        rd(16'hE020, 9);
        idle(2);
        for (int k = 0; k < 8; k++) begin
            wr(16'hE020, 8'(1 << k), 11);
            rd(16'hE001, 4);             // R4 each channel on its own
        end
        wr(16'hE020, 8'h00, 6);
        rd(16'hE01E, 6);
        wr(16'hE020, 8'hFF, 3);
        wr(16'hE00A, 8'hC3, 3);          // R3 all channels
        rd(16'hE00A, 5);
        rd(16'hE021, 5);
        cyc(1'b1, 16'h2021, 1'b1, 8'h00, 1);
        idle(2);
        idle(2);
        wait (q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule